// File: doc/BRIEF.md
# Multi-Format Audio Serial Transmitter

This block turns parallel audio words into one serial data line with a frame-sync output. The line can be framed as two-channel I2S, two-channel left-justified, multi-slot TDM with a one-bit data delay, or multi-slot TDM with no delay. The bit rate is set from outside: the block moves one bit each time the single-cycle `bclk_tick` enable is high. Everything inside runs on `clk`. The configuration pins fix the framing, the sample length, the slot width, the TDM slot count, the length of the sync pulse, mono duplication and what the block sends when a sample is missing.

Samples arrive on a valid/ready stream. Each word carries the channel index of the slot it belongs to. There is one holding register per channel. `in_ready` is high when the register of the channel currently on `in_chan` is empty, so a source that is held off must keep `in_chan` and `in_data` steady until the transfer completes. A word stays in its register until the start of its slot. A sender that keeps per-channel order never has to track frame timing. A word sent to a channel that the current framing never uses is never drained, and it stalls its source. The configuration is expected to change only while reset is active.

Top module: `aud_ser_tx`

## Requirements
- R1: `cfg_format` selects the framing: 0 is I2S, 1 is left-justified, 2 is TDM and 3 is TDM left-justified. In codes 0 and 2 the first bit of each frame's data comes one tick after the frame start. In codes 1 and 3 it comes on the frame-start tick itself.
- R2: In codes 0 and 1, a frame is two slots: channel 0 first, then channel 1. `frame_sync` is low for every bit of the channel 0 slot and high for every bit of the channel 1 slot.
- R3: `cfg_len_code` gives the sample length: 0 is 32 bits, 1 is 24, 2 is 20, 3 is 18, 4 and 5 are 16, and 6 and 7 are 8. The odd codes 5 and 7 serialize exactly like 4 and 6. The sample sits in the low bits of `in_data` and any higher bits are ignored. The sample goes out most significant bit first.
- R4: In codes 0 and 1, the slot is as wide as the sample for 8, 16 and 32 bits. For 18, 20 and 24 bits the slot is 32 bits wide when `cfg_slot_narrow` is 0 and 24 bits wide when it is 1. TDM slots are always 32 bits. Slot bits after the sample are sent as 0.
- R5: In codes 2 and 3, a frame has `cfg_chan_m1`+1 slots, and slot k carries channel k.
- R6: In codes 2 and 3, `frame_sync` is an active-high pulse that starts on the first bit of the frame. `cfg_sync_width` sets its length: 0 is the first slot, 1 is the first half of the frame, and 2 or 3 is one bit.
- R7: `in_ready` equals "the holding register of `in_chan` is empty". An accepted word is neither lost nor overwritten before its slot starts.
- R8: If a slot starts while its channel's register is empty, `underrun` bit k (k = channel) is high for exactly one `clk` cycle. With `cfg_ur_repeat` = 0 that slot sends a zero sample.
- R9: With `cfg_ur_repeat` = 1, an underrun slot resends the last word taken from that channel. If the channel has taken no word since reset, it sends zero.
- R10: With `cfg_mono` = 1, every odd slot repeats the word sent in the even slot before it. Odd channels then take no input words and never signal underrun.
- R11: After reset, `ser_data`, `frame_sync` and `underrun` are 0 and every channel register is empty. The first tick after reset is frame position 0. `ser_data` and `frame_sync` change only on the cycle after a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk_tick | input | 1 | One-cycle enable, one per serial bit |
| in_valid | input | 1 | Sample word valid |
| in_ready | output | 1 | Holding register of `in_chan` is empty |
| in_data | input | 32 | Sample, right-aligned |
| in_chan | input | 3 | Destination channel of the sample |
| cfg_format | input | 2 | Framing code (R1) |
| cfg_len_code | input | 3 | Sample length code (R3) |
| cfg_slot_narrow | input | 1 | 24-bit slots for 18/20/24-bit samples |
| cfg_chan_m1 | input | 3 | TDM slot count minus one |
| cfg_sync_width | input | 2 | TDM sync pulse length code (R6) |
| cfg_mono | input | 1 | Duplicate even slots into odd slots |
| cfg_ur_repeat | input | 1 | Underrun policy: 0 sends zero, 1 repeats |
| ser_data | output | 1 | Serial data |
| frame_sync | output | 1 | Frame sync |
| underrun | output | 8 | Per-channel one-cycle underrun pulse |

## Verification
The embedded properties cover the handshake on every cycle. A full holding register keeps its word until its own slot drains it, and a slot never drains an empty register. The same properties confirm that underrun pulses are one-hot, last one cycle and follow a tick, and that the serial outputs and position counters hold still between ticks. Bit order, the one-bit delay, the sync shapes for each framing and width, the sample-to-slot padding, mono duplication and the two underrun fill policies all depend on complete frames. The directed scenarios show these by comparing every serial bit with a frame image built from the requirements.

// File: rtl/aud_tx_pkg.sv
package aud_tx_pkg;

  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    FMT_I2S    = 2'd0,
    FMT_LJ     = 2'd1,
    FMT_TDM    = 2'd2,
    FMT_TDM_LJ = 2'd3
  } aud_fmt_e;

  typedef enum logic [1:0] {
    SYNC_SLOT  = 2'd0,
    SYNC_HALF  = 2'd1,
    SYNC_BIT   = 2'd2,
    SYNC_BIT_B = 2'd3
  } sync_w_e;

  function automatic logic is_tdm(input logic [1:0] fmt);
    return fmt[1];
  endfunction

  // Codes 0 and 2 put a one-bit gap between frame start and data.
  function automatic logic has_delay(input logic [1:0] fmt);
    return !fmt[0];
  endfunction

  function automatic logic [5:0] sample_bits(input logic [2:0] code);
    case (code)
      3'd0:       return 6'd32;
      3'd1:       return 6'd24;
      3'd2:       return 6'd20;
      3'd3:       return 6'd18;
      3'd4, 3'd5: return 6'd16;
      default:    return 6'd8;
    endcase
  endfunction

  function automatic logic [5:0] slot_bits(input logic [1:0] fmt,
                                           input logic [2:0] code,
                                           input logic       narrow);
    if (fmt[1]) return 6'(WORD_W);
    case (code)
      3'd0:             return 6'd32;
      3'd1, 3'd2, 3'd3: return narrow ? 6'd24 : 6'd32;
      3'd4, 3'd5:       return 6'd16;
      default:          return 6'd8;
    endcase
  endfunction

endpackage

// File: rtl/aud_tx_framer.sv
module aud_tx_framer
  import aud_tx_pkg::*;
#(
  parameter int MAX_CH = 8,
  parameter int CH_W   = $clog2(MAX_CH),
  parameter int POS_W  = $clog2(MAX_CH * WORD_W + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic [1:0]      fmt,
  input  logic [2:0]      len_code,
  input  logic            narrow,
  input  logic [CH_W-1:0] chan_m1,
  input  logic [1:0]      sync_width,
  output logic            data_act,
  output logic            slot_start,
  output logic [CH_W-1:0] slot_idx,
  output logic            sync_bit
);

  logic [5:0]       slot_w;
  logic [CH_W:0]    nslots;
  logic [POS_W-1:0] flen;
  logic [CH_W-1:0]  last_slot;
  logic [POS_W-1:0] fpos_q;
  logic [5:0]       dbit_q;
  logic [CH_W-1:0]  dslot_q;
  logic             pre_q;

  assign slot_w    = slot_bits(fmt, len_code, narrow);
  assign nslots    = is_tdm(fmt) ? ({1'b0, chan_m1} + (CH_W+1)'(1)) : (CH_W+1)'(2);
  assign flen      = POS_W'(nslots) * POS_W'(slot_w);
  assign last_slot = is_tdm(fmt) ? chan_m1 : CH_W'(1);

  // The data side waits one tick after reset when the framing has a delay.
  assign data_act   = !(pre_q && has_delay(fmt));
  assign slot_start = data_act && (dbit_q == 6'd0);
  assign slot_idx   = dslot_q;

  always_comb begin
    if (is_tdm(fmt)) begin
      case (sync_w_e'(sync_width))
        SYNC_SLOT: sync_bit = fpos_q < POS_W'(WORD_W);
        SYNC_HALF: sync_bit = fpos_q < (flen >> 1);
        default:   sync_bit = fpos_q == '0;
      endcase
    end else begin
      sync_bit = fpos_q >= POS_W'(slot_w);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fpos_q  <= '0;
      dbit_q  <= '0;
      dslot_q <= '0;
      pre_q   <= 1'b1;
    end else if (tick) begin
      pre_q  <= 1'b0;
      fpos_q <= (fpos_q >= flen - POS_W'(1)) ? '0 : fpos_q + POS_W'(1);
      if (data_act) begin
        if (dbit_q >= slot_w - 6'd1) begin
          dbit_q  <= '0;
          dslot_q <= (dslot_q >= last_slot) ? '0 : dslot_q + CH_W'(1);
        end else begin
          dbit_q <= dbit_q + 6'd1;
        end
      end
    end
  end

  // R11: frame and bit positions move only on a tick
  a_r11_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(fpos_q) && $stable(dbit_q) && $stable(dslot_q));

endmodule

// File: rtl/aud_tx_slot_buf.sv
module aud_tx_slot_buf
  import aud_tx_pkg::*;
#(
  parameter int MAX_CH = 8,
  parameter int CH_W   = $clog2(MAX_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  input  logic [CH_W-1:0]   in_chan,
  input  logic              take,
  input  logic [CH_W-1:0]   take_idx,
  output logic              has_word,
  output logic [WORD_W-1:0] word,
  output logic [WORD_W-1:0] last_word
);

  logic [MAX_CH-1:0] full_q;
  logic [WORD_W-1:0] hold_q [MAX_CH];
  logic [WORD_W-1:0] prev_q [MAX_CH];
  logic              wr;

  assign in_ready  = !full_q[in_chan];
  assign wr        = in_valid && in_ready;
  assign has_word  = full_q[take_idx];
  assign word      = hold_q[take_idx];
  assign last_word = prev_q[take_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= '0;
      for (int c = 0; c < MAX_CH; c++) begin
        hold_q[c] <= '0;
        prev_q[c] <= '0;
      end
    end else begin
      for (int c = 0; c < MAX_CH; c++) begin
        if (take && take_idx == CH_W'(c)) begin
          full_q[c] <= 1'b0;
          prev_q[c] <= hold_q[c];
        end
        if (wr && in_chan == CH_W'(c)) begin
          full_q[c] <= 1'b1;
          hold_q[c] <= in_data;
        end
      end
    end
  end

  // R7: a slot only drains a register that holds a word
  a_r7_take_full: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> has_word);

  for (genvar c = 0; c < MAX_CH; c++) begin : g_chk
    // R7: a waiting word survives until its own slot drains it
    a_r7_hold_kept: assert property (@(posedge clk) disable iff (!rst_n)
      full_q[c] && !(take && take_idx == CH_W'(c)) |=> full_q[c] && $stable(hold_q[c]));
  end

endmodule

// File: rtl/aud_tx_shifter.sv
module aud_tx_shifter
  import aud_tx_pkg::*;
#(
  parameter int MAX_CH = 8,
  parameter int CH_W   = $clog2(MAX_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              data_act,
  input  logic              slot_start,
  input  logic [CH_W-1:0]   slot_idx,
  input  logic              sync_bit,
  input  logic [2:0]        len_code,
  input  logic              mono,
  input  logic              ur_repeat,
  input  logic              has_word,
  input  logic [WORD_W-1:0] word,
  input  logic [WORD_W-1:0] last_word,
  output logic              take,
  output logic [CH_W-1:0]   take_idx,
  output logic              ser_data,
  output logic              frame_sync,
  output logic [MAX_CH-1:0] underrun
);

  logic              mono_odd;
  logic              miss;
  logic [5:0]        dlen;
  logic [WORD_W-1:0] raw;
  logic [WORD_W-1:0] aligned;
  logic [WORD_W-1:0] chosen;
  logic [WORD_W-1:0] sh_q;
  logic [WORD_W-1:0] pair_q;
  logic              sdata_q;
  logic              fsync_q;
  logic [MAX_CH-1:0] ur_q;

  assign mono_odd = mono && slot_idx[0];
  assign take     = tick && slot_start && !mono_odd && has_word;
  assign miss     = tick && slot_start && !mono_odd && !has_word;
  assign take_idx = slot_idx;
  assign dlen     = sample_bits(len_code);
  assign raw      = has_word ? word : (ur_repeat ? last_word : '0);
  assign aligned  = raw << (6'(WORD_W) - dlen);
  assign chosen   = mono_odd ? pair_q : aligned;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q    <= '0;
      pair_q  <= '0;
      sdata_q <= 1'b0;
      fsync_q <= 1'b0;
      ur_q    <= '0;
    end else begin
      ur_q <= miss ? (MAX_CH'(1) << slot_idx) : '0;
      if (tick) begin
        fsync_q <= sync_bit;
        if (slot_start) begin
          sdata_q <= chosen[WORD_W-1];
          sh_q    <= chosen << 1;
          if (!mono_odd) pair_q <= aligned;
        end else if (data_act) begin
          sdata_q <= sh_q[WORD_W-1];
          sh_q    <= sh_q << 1;
        end else begin
          sdata_q <= 1'b0;
        end
      end
    end
  end

  assign ser_data   = sdata_q;
  assign frame_sync = fsync_q;
  assign underrun   = ur_q;

  // R8: at most one channel flags underrun at a time
  a_r8_ur_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ur_q));

  // R8: an underrun pulse always follows a tick
  a_r8_ur_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (|ur_q) |-> $past(tick));

  // R11: serial outputs hold between ticks
  a_r11_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(sdata_q) && $stable(fsync_q));

endmodule

// File: rtl/aud_ser_tx.sv
module aud_ser_tx
  import aud_tx_pkg::*;
#(
  parameter int MAX_CH = 8,
  parameter int CH_W   = $clog2(MAX_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk_tick,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  input  logic [CH_W-1:0]   in_chan,
  input  logic [1:0]        cfg_format,
  input  logic [2:0]        cfg_len_code,
  input  logic              cfg_slot_narrow,
  input  logic [CH_W-1:0]   cfg_chan_m1,
  input  logic [1:0]        cfg_sync_width,
  input  logic              cfg_mono,
  input  logic              cfg_ur_repeat,
  output logic              ser_data,
  output logic              frame_sync,
  output logic [MAX_CH-1:0] underrun
);

  logic              data_act;
  logic              slot_start;
  logic [CH_W-1:0]   slot_idx;
  logic              sync_bit;
  logic              take;
  logic [CH_W-1:0]   take_idx;
  logic              has_word;
  logic [WORD_W-1:0] word;
  logic [WORD_W-1:0] last_word;

  aud_tx_framer #(.MAX_CH(MAX_CH), .CH_W(CH_W)) framer_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (bclk_tick),
    .fmt        (cfg_format),
    .len_code   (cfg_len_code),
    .narrow     (cfg_slot_narrow),
    .chan_m1    (cfg_chan_m1),
    .sync_width (cfg_sync_width),
    .data_act   (data_act),
    .slot_start (slot_start),
    .slot_idx   (slot_idx),
    .sync_bit   (sync_bit)
  );

  aud_tx_slot_buf #(.MAX_CH(MAX_CH), .CH_W(CH_W)) buf_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .in_chan   (in_chan),
    .take      (take),
    .take_idx  (take_idx),
    .has_word  (has_word),
    .word      (word),
    .last_word (last_word)
  );

  aud_tx_shifter #(.MAX_CH(MAX_CH), .CH_W(CH_W)) shift_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (bclk_tick),
    .data_act   (data_act),
    .slot_start (slot_start),
    .slot_idx   (slot_idx),
    .sync_bit   (sync_bit),
    .len_code   (cfg_len_code),
    .mono       (cfg_mono),
    .ur_repeat  (cfg_ur_repeat),
    .has_word   (has_word),
    .word       (word),
    .last_word  (last_word),
    .take       (take),
    .take_idx   (take_idx),
    .ser_data   (ser_data),
    .frame_sync (frame_sync),
    .underrun   (underrun)
  );

endmodule

// File: tb/aud_ser_tx_tb_top.sv
module aud_ser_tx_tb_top;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bclk_tick = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic [2:0]  in_chan = '0;
  logic [1:0]  cfg_format = '0;
  logic [2:0]  cfg_len_code = '0;
  logic        cfg_slot_narrow = 1'b0;
  logic [2:0]  cfg_chan_m1 = '0;
  logic [1:0]  cfg_sync_width = '0;
  logic        cfg_mono = 1'b0;
  logic        cfg_ur_repeat = 1'b0;
  logic        ser_data;
  logic        frame_sync;
  logic [7:0]  underrun;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  int          q_ch [64];
  logic [31:0] q_dat [64];
  int          qn = 0;
  int          qh = 0;
  int          ur_got [8];
  bit          got_d [1024];
  bit          got_f [1024];
  int          nk = 0;
  logic [31:0] smp [4][8];

  always #(CLK_P/2) clk = ~clk;

  aud_ser_tx dut_i (
    .clk(clk), .rst_n(rst_n), .bclk_tick(bclk_tick),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_chan(in_chan),
    .cfg_format(cfg_format), .cfg_len_code(cfg_len_code), .cfg_slot_narrow(cfg_slot_narrow),
    .cfg_chan_m1(cfg_chan_m1), .cfg_sync_width(cfg_sync_width), .cfg_mono(cfg_mono),
    .cfg_ur_repeat(cfg_ur_repeat), .ser_data(ser_data), .frame_sync(frame_sync),
    .underrun(underrun)
  );

  task automatic chk(input string tag, input bit ok, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int b_dlen(input int code);
    case (code)
      0: return 32;
      1: return 24;
      2: return 20;
      3: return 18;
      4, 5: return 16;
      default: return 8;
    endcase
  endfunction

  function automatic int b_slot(input int fmt, input int code, input int nar);
    if (fmt >= 2) return 32;
    case (code)
      0: return 32;
      1, 2, 3: return nar ? 24 : 32;
      4, 5: return 16;
      default: return 8;
    endcase
  endfunction

  // One clk cycle: drive at negedge, sample 1 ns after the posedge.
  task automatic step(input logic tk);
    logic acc;
    @(negedge clk);
    bclk_tick = tk;
    if (qh < qn) begin
      in_valid = 1'b1;
      in_chan  = 3'(q_ch[qh]);
      in_data  = q_dat[qh];
    end else begin
      in_valid = 1'b0;
    end
    #1;
    acc = in_valid && in_ready;
    @(posedge clk);
    #1;
    if (acc) qh++;
    for (int c = 0; c < 8; c++) ur_got[c] += int'(underrun[c]);
    if (tk) begin
      got_d[nk] = ser_data;
      got_f[nk] = frame_sync;
      nk++;
    end
  endtask

  task automatic do_reset();
    qn = 0;
    qh = 0;
    @(negedge clk);
    rst_n = 1'b0;
    bclk_tick = 1'b0;
    in_valid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  function automatic void fill_samples();
    for (int f = 0; f < 4; f++)
      for (int c = 0; c < 8; c++)
        smp[f][c] = {8'(f*37 + c*11 + 129), 8'(c*53 + 7), 8'(f*91 + c*3 + 13), 8'(f + c*29 + 99)};
  endfunction

  // Runs nfr frames with words for the first nprov frames, then checks every bit.
  task automatic run_case(input string tag, input int nfr, input int nprov);
    int nsl, sw, dl, flen, dly, total, ed, ef, fp, pos;
    int errs_d, errs_f, first_d, first_f, ur_bad, ur_bad_ch;
    logic [31:0] prevw [8];
    logic [31:0] pairw, aw, v;
    int ur_exp [8];
    bit ds [1024];
    bit odd;
    do_reset();
    nsl  = (cfg_format >= 2) ? int'(cfg_chan_m1) + 1 : 2;
    sw   = b_slot(int'(cfg_format), int'(cfg_len_code), int'(cfg_slot_narrow));
    dl   = b_dlen(int'(cfg_len_code));
    flen = nsl * sw;
    dly  = (cfg_format == 2'd0 || cfg_format == 2'd2) ? 1 : 0;
    total = nfr * flen + dly;
    for (int f = 0; f < nprov; f++)
      for (int c = 0; c < nsl; c++)
        if (!(cfg_mono && (c % 2 == 1))) begin
          q_ch[qn] = c;
          q_dat[qn] = smp[f][c];
          qn++;
        end
    for (int c = 0; c < 8; c++) begin ur_got[c] = 0; ur_exp[c] = 0; prevw[c] = '0; end
    nk = 0;
    repeat (6) step(1'b0);
    for (int k = 0; k < total; k++) begin
      step(1'b1);
      repeat (3) step(1'b0);
    end
    // expected frame image
    pairw = '0;
    for (int f = 0; f < nfr; f++)
      for (int s = 0; s < nsl; s++) begin
        odd = cfg_mono && (s % 2 == 1);
        if (odd) aw = pairw;
        else begin
          if (f < nprov) begin
            v = smp[f][s];
            prevw[s] = v;
          end else begin
            ur_exp[s]++;
            v = cfg_ur_repeat ? prevw[s] : '0;
          end
          aw = v << (32 - dl);
          pairw = aw;
        end
        for (int b = 0; b < sw; b++) begin
          pos = (f * nsl + s) * sw + b;
          ds[pos] = aw[31 - b];
        end
      end
    errs_d = 0; errs_f = 0; first_d = -1; first_f = -1;
    for (int k = 0; k < total; k++) begin
      ed = (k < dly) ? 0 : int'(ds[k - dly]);
      fp = k % flen;
      if (cfg_format >= 2) begin
        if (cfg_sync_width == 2'd0) ef = (fp < 32) ? 1 : 0;
        else if (cfg_sync_width == 2'd1) ef = (fp < flen / 2) ? 1 : 0;
        else ef = (fp == 0) ? 1 : 0;
      end else ef = (fp >= sw) ? 1 : 0;
      if (int'(got_d[k]) != ed) begin errs_d++; if (first_d < 0) first_d = k; end
      if (int'(got_f[k]) != ef) begin errs_f++; if (first_f < 0) first_f = k; end
    end
    chk(tag, errs_d == 0, $sformatf("ser_data mismatches (first at tick %0d)", first_d), errs_d, 0);
    chk(tag, errs_f == 0, $sformatf("frame_sync mismatches (first at tick %0d)", first_f), errs_f, 0);
    ur_bad = 0; ur_bad_ch = 0;
    for (int c = 0; c < 8; c++)
      if (ur_got[c] != ur_exp[c] && ur_bad == 0) begin ur_bad = 1; ur_bad_ch = c; end
    chk(tag, ur_bad == 0, $sformatf("underrun pulses on channel %0d", ur_bad_ch),
        ur_got[ur_bad_ch], ur_exp[ur_bad_ch]);
  endtask

  task automatic set_cfg(input int fmt, input int code, input int nar, input int chm1,
                         input int sw, input int mono, input int rep);
    cfg_format = 2'(fmt); cfg_len_code = 3'(code); cfg_slot_narrow = 1'(nar);
    cfg_chan_m1 = 3'(chm1); cfg_sync_width = 2'(sw); cfg_mono = 1'(mono);
    cfg_ur_repeat = 1'(rep);
  endtask

  task automatic tc_reset_and_ready();
    set_cfg(0, 4, 0, 0, 0, 0, 0);
    do_reset();
    #1;
    chk("R11", ser_data == 1'b0, "ser_data after reset", ser_data, 0);
    chk("R11", frame_sync == 1'b0, "frame_sync after reset", frame_sync, 0);
    chk("R11", underrun == 8'h00, "underrun after reset", underrun, 0);
    chk("R7", in_ready == 1'b1, "in_ready empty register", in_ready, 1);
    @(negedge clk);
    in_valid = 1'b1; in_chan = 3'd0; in_data = 32'h0000_ABCD;
    @(posedge clk); #1;
    in_valid = 1'b0; in_chan = 3'd0;
    #1;
    chk("R7", in_ready == 1'b0, "in_ready channel 0 full", in_ready, 0);
    in_chan = 3'd1;
    #1;
    chk("R7", in_ready == 1'b1, "in_ready channel 1 empty", in_ready, 1);
    repeat (5) @(posedge clk);
    #1;
    chk("R11", ser_data == 1'b0 && frame_sync == 1'b0, "outputs moved without tick",
        {ser_data, frame_sync}, 0);
  endtask

  task automatic tc_i2s16();      set_cfg(0, 4, 0, 0, 0, 0, 0); run_case("R1 R2 R3", 3, 3); endtask
  task automatic tc_lj24_narrow(); set_cfg(1, 1, 1, 0, 0, 0, 0); run_case("R1 R2 R4", 2, 2); endtask
  task automatic tc_lj20_wide();  set_cfg(1, 2, 0, 0, 0, 0, 0); run_case("R3 R4", 2, 2); endtask
  task automatic tc_i2s18_narrow(); set_cfg(0, 3, 1, 0, 0, 0, 0); run_case("R3 R4", 2, 2); endtask
  task automatic tc_i2s32();      set_cfg(0, 0, 0, 0, 0, 0, 0); run_case("R1 R3", 2, 2); endtask
  task automatic tc_lj8c();       set_cfg(1, 7, 0, 0, 0, 0, 0); run_case("R3 R4", 3, 3); endtask
  task automatic tc_tdm4_slot();  set_cfg(2, 4, 0, 3, 0, 0, 0); run_case("R1 R5 R6 R4", 2, 2); endtask
  task automatic tc_tdmlj8_bit(); set_cfg(3, 1, 1, 7, 2, 0, 0); run_case("R5 R6 R7", 2, 2); endtask
  task automatic tc_tdm3_half();  set_cfg(2, 0, 0, 2, 1, 0, 0); run_case("R5 R6", 2, 2); endtask
  task automatic tc_mono_i2s();   set_cfg(0, 4, 0, 0, 0, 1, 0); run_case("R10", 2, 2); endtask
  task automatic tc_mono_tdm();   set_cfg(3, 6, 0, 3, 0, 1, 0); run_case("R10", 2, 2); endtask
  task automatic tc_ur_zero();    set_cfg(0, 4, 0, 0, 0, 0, 0); run_case("R8", 3, 1); endtask
  task automatic tc_ur_repeat();  set_cfg(3, 4, 0, 2, 2, 0, 1); run_case("R9", 3, 1); endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    fill_samples();
    tc_reset_and_ready();
    tc_i2s16();
    tc_lj24_narrow();
    tc_lj20_wide();
    tc_i2s18_narrow();
    tc_i2s32();
    tc_lj8c();
    tc_tdm4_slot();
    tc_tdmlj8_bit();
    tc_tdm3_half();
    tc_mono_i2s();
    tc_mono_tdm();
    tc_ur_zero();
    tc_ur_repeat();
    done = 1;
    summary();
    $finish;
  end

  initial begin
    #(CLK_P * 180000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R11 watchdog expired: actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end

endmodule